// File: doc/BRIEF.md
# PLL Control Register Interlock Unit

This block holds the byte-wide software registers of a PLL clock generator. There is a control register, a mode register, and the two programming registers: a VCO range value and a reference divide value. Software reaches them through a simple bus with an address, a read strobe and a write strobe. Read data comes out combinationally from the current register state. The analog PLL, the VCO, the lock detector and the clock multiplexer sit outside the block. The block drives their settings and receives the raw lock indication.

The registers are not independent. Hardware interlocks decide, from the state before each write, which bits may change and which bits are forced.

- The base-clock select can only be set while the PLL is enabled and the VCO range is non-zero.
- While the base-clock select is set, the PLL enable stays on.
- An enabled PLL freezes both programming registers.
- Automatic mode gates the lock status, the lock flag and the interrupt enable.
- Automatic mode makes the acquisition bit read-only.

The lock input is synchronized. Either edge of it sets a lock-change flag, which can raise an interrupt.

Top module: `pllreg_interlock`

## Requirements
- R1: After reset the control register reads 0x20, the mode register 0x00, the VCO range register 0x40 and the reference divide register 0x01. The default register offsets are control 0x36, mode 0x37, VCO range 0x3A and reference divide 0x3B.
- R2: Control register bit layout:
  - bit 7: interrupt enable
  - bit 6: lock-change flag
  - bit 5: PLL enable
  - bit 4: base-clock select
  - bits 3:2: prescaler, freely writable
  - bits 1:0: VCO power range, freely writable
- R3: The reference divide register stores only its low four bits. Its bits 7:4 always read 0.
- R4: Mode register bit 7 is the automatic-mode bit. While it is 0:
  - the interrupt enable is held clear and ignores writes;
  - the flag reads 0;
  - the lock bit (mode register bit 6) reads 0;
  - no interrupt is raised.
- R5: Mode register bit 5 is the acquisition bit. It takes writes only while automatic mode was 0 before the write. Otherwise it keeps its value.
- R6: The base-clock select is 0 whenever the PLL enable is 0 or the VCO range is 0x00. A write can set it only if the PLL was already enabled and the range was non-zero.
- R7: While the PLL enable is 1, writes to the VCO range and reference divide registers are ignored.
- R8: While the base-clock select is 1, a write of 0 to the PLL enable is ignored and the enable stays 1.
- R9: Either edge of the lock input sets the flag at the third rising clock edge after the change. The lock bit follows the input after the second edge.
- R10: The interrupt output is high exactly when the flag and the interrupt enable are both set in automatic mode.
- R11: Writes to the flag bit have no effect. A read of the control register clears the flag, unless a lock change sets it on the same edge; the set wins.
- R12: Bits written together in one control write are judged against the register state before that write. A PLL enable and a base-clock select written as 1 from a disabled state leave the select at 0.
- R13: Addresses that map to no register read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_rd | input | 1 | Read strobe; a control read clears the flag at the edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| lock_in | input | 1 | Asynchronous lock indication from the detector |
| irq_o | output | 1 | Lock-change interrupt request |
| pll_en_o | output | 1 | PLL enable |
| base_sel_o | output | 1 | Base-clock select |
| presc_o | output | 2 | Prescaler setting |
| vco_pow_o | output | 2 | VCO power range |
| vco_range_o | output | 8 | VCO range value |
| ref_div_o | output | 4 | Reference divide value |
| auto_o | output | 1 | Automatic-mode bit |
| acq_o | output | 1 | Acquisition bit |

## Verification
Read data is combinational. The bench samples it one nanosecond after putting the address on the bus, in the low phase before the capturing edge. A write shows up in the read one edge after its strobe. The lock bit is expected after two rising edges from an input change, and the flag and interrupt after three. The bench counts edges at falling edges and checks both one edge early (still low) and on time. The priority case places a control read exactly on the third edge, so the flag-set and flag-clear collide.

// File: rtl/pllreg_pkg.sv
package pllreg_pkg;

  localparam int DATA_W = 8;

  typedef struct packed {
    logic       int_en;
    logic       flag;
    logic       pll_en;
    logic       base_sel;
    logic [1:0] presc;
    logic [1:0] vco_pow;
  } ctrl_t;

  localparam ctrl_t      CTRL_RST  = ctrl_t'(8'h20);
  localparam logic [7:0] RANGE_RST = 8'h40;
  localparam logic [3:0] DIV_RST   = 4'h1;

endpackage

// File: rtl/pllreg_sync.sv
module pllreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb pipe_d = d;
    end else begin : g_chain
      always_comb pipe_d = {pipe_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/pllreg_ctrl.sv
module pllreg_ctrl
  import pllreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       w_int_en,
  input  logic       w_pll_en,
  input  logic       w_base_sel,
  input  logic [1:0] w_presc,
  input  logic [1:0] w_vco_pow,
  input  logic       auto_mode,
  input  logic       range_nz,
  input  logic       lock_s,
  output ctrl_t      ctrl_q,
  output logic [7:0] view,
  output logic       irq
);

  ctrl_t ctrl_d;
  logic  lock_prev_q;
  logic  toggle;
  logic  sel_allow;
  logic  sel_ld;

  always_comb begin
    toggle    = lock_s ^ lock_prev_q;
    // permissions come from the state before the write
    sel_allow = ctrl_q.pll_en & range_nz;
    sel_ld    = wr_en & sel_allow;
    ctrl_d    = ctrl_q;

    if (!auto_mode)  ctrl_d.int_en = 1'b0;
    else if (wr_en)  ctrl_d.int_en = w_int_en;

    if (ctrl_q.base_sel) ctrl_d.pll_en = 1'b1;
    else if (wr_en)      ctrl_d.pll_en = w_pll_en;

    ctrl_d.base_sel = ctrl_d.pll_en & range_nz &
                      (sel_ld ? w_base_sel : ctrl_q.base_sel);

    if (wr_en) begin
      ctrl_d.presc   = w_presc;
      ctrl_d.vco_pow = w_vco_pow;
    end

    if (toggle)     ctrl_d.flag = 1'b1;
    else if (rd_en) ctrl_d.flag = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= CTRL_RST;
      lock_prev_q <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      lock_prev_q <= lock_s;
    end
  end

  always_comb begin
    view    = ctrl_q;
    view[7] = ctrl_q.int_en & auto_mode;
    view[6] = ctrl_q.flag & auto_mode;
    irq     = ctrl_q.flag & ctrl_q.int_en & auto_mode;
  end

endmodule

// File: rtl/pllreg_prog.sv
module pllreg_prog
  import pllreg_pkg::*;
#(
  parameter int RANGE_W = 8,
  parameter int DIV_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pll_en,
  input  logic               wr_range,
  input  logic               wr_div,
  input  logic [RANGE_W-1:0] w_range,
  input  logic [DIV_W-1:0]   w_div,
  output logic [RANGE_W-1:0] range_q,
  output logic [DIV_W-1:0]   div_q,
  output logic               range_nz
);

  logic               ld_range;
  logic               ld_div;
  logic [RANGE_W-1:0] range_d;
  logic [DIV_W-1:0]   div_d;

  always_comb begin
    ld_range = wr_range & ~pll_en;
    ld_div   = wr_div & ~pll_en;
    range_d  = ld_range ? w_range : range_q;
    div_d    = ld_div ? w_div : div_q;
    range_nz = |range_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_q <= RANGE_W'(RANGE_RST);
      div_q   <= DIV_W'(DIV_RST);
    end else begin
      range_q <= range_d;
      div_q   <= div_d;
    end
  end

endmodule

// File: rtl/pllreg_mode.sv
module pllreg_mode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       w_auto,
  input  logic       w_acq,
  input  logic       lock_s,
  output logic       auto_q,
  output logic       acq_q,
  output logic [7:0] view
);

  logic auto_d;
  logic acq_d;
  logic acq_ld;

  always_comb begin
    acq_ld = wr_en & ~auto_q;
    auto_d = wr_en ? w_auto : auto_q;
    acq_d  = acq_ld ? w_acq : acq_q;
    view   = {auto_q, lock_s & auto_q, acq_q, 5'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0;
      acq_q  <= 1'b0;
    end else begin
      auto_q <= auto_d;
      acq_q  <= acq_d;
    end
  end

endmodule

// File: rtl/pllreg_interlock.sv
module pllreg_interlock
  import pllreg_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h36,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 8'h37,
  parameter logic [ADDR_W-1:0] RANGE_ADDR = 8'h3A,
  parameter logic [ADDR_W-1:0] DIV_ADDR   = 8'h3B,
  parameter int              SYNC_STAGES = 2,
  parameter int              RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              lock_in,
  output logic              irq_o,
  output logic              pll_en_o,
  output logic              base_sel_o,
  output logic [1:0]        presc_o,
  output logic [1:0]        vco_pow_o,
  output logic [7:0]        vco_range_o,
  output logic [3:0]        ref_div_o,
  output logic              auto_o,
  output logic              acq_o
);

  localparam int RANGE_W = 8;
  localparam int DIV_W   = 4;

  logic       rst_sync_n;
  logic       lock_s;
  logic       hit_ctrl, hit_mode, hit_range, hit_div;
  logic       range_nz;
  logic [7:0] ctrl_view;
  logic [7:0] mode_view;
  logic       unused_wbit;
  ctrl_t      ctrl_q;

  assign unused_wbit = bus_wdata[6];

  pllreg_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  pllreg_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(lock_in), .q(lock_s)
  );

  always_comb begin
    hit_ctrl  = (bus_addr == CTRL_ADDR);
    hit_mode  = (bus_addr == MODE_ADDR);
    hit_range = (bus_addr == RANGE_ADDR);
    hit_div   = (bus_addr == DIV_ADDR);
  end

  pllreg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (bus_wr & hit_ctrl),
    .rd_en     (bus_rd & hit_ctrl),
    .w_int_en  (bus_wdata[7]),
    .w_pll_en  (bus_wdata[5]),
    .w_base_sel(bus_wdata[4]),
    .w_presc   (bus_wdata[3:2]),
    .w_vco_pow (bus_wdata[1:0]),
    .auto_mode (auto_o),
    .range_nz  (range_nz),
    .lock_s    (lock_s),
    .ctrl_q    (ctrl_q),
    .view      (ctrl_view),
    .irq       (irq_o)
  );

  pllreg_prog #(.RANGE_W(RANGE_W), .DIV_W(DIV_W)) u_prog (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pll_en  (ctrl_q.pll_en),
    .wr_range(bus_wr & hit_range),
    .wr_div  (bus_wr & hit_div),
    .w_range (bus_wdata[RANGE_W-1:0]),
    .w_div   (bus_wdata[DIV_W-1:0]),
    .range_q (vco_range_o),
    .div_q   (ref_div_o),
    .range_nz(range_nz)
  );

  pllreg_mode u_mode (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (bus_wr & hit_mode),
    .w_auto(bus_wdata[7]),
    .w_acq (bus_wdata[5]),
    .lock_s(lock_s),
    .auto_q(auto_o),
    .acq_q (acq_o),
    .view  (mode_view)
  );

  always_comb begin
    if (hit_ctrl)       bus_rdata = ctrl_view;
    else if (hit_mode)  bus_rdata = mode_view;
    else if (hit_range) bus_rdata = vco_range_o;
    else if (hit_div)   bus_rdata = {4'b0, ref_div_o};
    else                bus_rdata = 8'h00;
  end

  assign pll_en_o   = ctrl_q.pll_en;
  assign base_sel_o = ctrl_q.base_sel;
  assign presc_o    = ctrl_q.presc;
  assign vco_pow_o  = ctrl_q.vco_pow;

endmodule

// File: rtl/pllreg_interlock_chk.sv
module pllreg_interlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_en,
  input logic       base_sel,
  input logic [7:0] vco_range,
  input logic [3:0] ref_div,
  input logic       auto_mode,
  input logic       irq,
  input logic       lock_s,
  input logic       flag
);

  AST_SEL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !base_sel);  // R6
  AST_SEL_NEEDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_range == 8'h00) |-> !base_sel);  // R6
  AST_PROG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pll_en) |-> ($stable(vco_range) && $stable(ref_div)));  // R7
  AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(base_sel) |-> pll_en);  // R8
  AST_NO_IRQ_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |-> !irq);  // R4
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);  // R10
  AST_TOGGLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_s) != $past(lock_s, 2)) |-> flag);  // R9

endmodule

bind pllreg_interlock pllreg_interlock_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .pll_en   (pll_en_o),
  .base_sel (base_sel_o),
  .vco_range(vco_range_o),
  .ref_div  (ref_div_o),
  .auto_mode(auto_o),
  .irq      (irq_o),
  .lock_s   (lock_s),
  .flag     (ctrl_q.flag)
);

// File: tb/pllreg_interlock_bench.sv
`timescale 1ns/1ps
module pllreg_interlock_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       lock_in;
  logic       irq_o, pll_en_o, base_sel_o, auto_o, acq_o;
  logic [1:0] presc_o, vco_pow_o;
  logic [7:0] vco_range_o;
  logic [3:0] ref_div_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  pllreg_interlock u_pllreg_interlock (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lock_in(lock_in), .irq_o(irq_o), .pll_en_o(pll_en_o),
    .base_sel_o(base_sel_o), .presc_o(presc_o), .vco_pow_o(vco_pow_o),
    .vco_range_o(vco_range_o), .ref_div_o(ref_div_o), .auto_o(auto_o),
    .acq_o(acq_o)
  );

  // {is_write, address, data or expected, requirement number}
  localparam int NV = 41;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 8'h36, 8'h20, 4'd1},  // R1 control reset
    {1'b0, 8'h3A, 8'h40, 4'd1},  // R1 range reset
    {1'b0, 8'h3B, 8'h01, 4'd1},  // R1 divide reset
    {1'b0, 8'h37, 8'h00, 4'd1},  // R1 mode reset
    {1'b1, 8'h36, 8'h2F, 4'd2},  // R2 prescaler and power bits
    {1'b0, 8'h36, 8'h2F, 4'd2},
    {1'b1, 8'h3A, 8'h12, 4'd7},  // R7 range frozen
    {1'b0, 8'h3A, 8'h40, 4'd7},
    {1'b1, 8'h3B, 8'h0F, 4'd7},  // R7 divide frozen
    {1'b0, 8'h3B, 8'h01, 4'd7},
    {1'b1, 8'h36, 8'hD0, 4'd12}, // R12 R4 R11 combined write
    {1'b0, 8'h36, 8'h00, 4'd12},
    {1'b1, 8'h3A, 8'h00, 4'd7},  // R7 writable when disabled
    {1'b0, 8'h3A, 8'h00, 4'd7},
    {1'b1, 8'h3B, 8'hF9, 4'd3},  // R3 low nibble only
    {1'b0, 8'h3B, 8'h09, 4'd3},
    {1'b1, 8'h36, 8'h30, 4'd12}, // R12 enable and select from off
    {1'b0, 8'h36, 8'h20, 4'd12},
    {1'b1, 8'h36, 8'h30, 4'd6},  // R6 range zero blocks select
    {1'b0, 8'h36, 8'h20, 4'd6},
    {1'b1, 8'h36, 8'h00, 4'd6},
    {1'b1, 8'h3A, 8'h81, 4'd6},
    {1'b1, 8'h36, 8'h20, 4'd6},
    {1'b1, 8'h36, 8'h30, 4'd6},
    {1'b0, 8'h36, 8'h30, 4'd6},
    {1'b1, 8'h36, 8'h10, 4'd8},  // R8 enable held by select
    {1'b0, 8'h36, 8'h30, 4'd8},
    {1'b1, 8'h3A, 8'h22, 4'd7},
    {1'b0, 8'h3A, 8'h81, 4'd7},
    {1'b1, 8'h38, 8'hFF, 4'd13}, // R13 unmapped
    {1'b0, 8'h38, 8'h00, 4'd13},
    {1'b0, 8'h36, 8'h30, 4'd13},
    {1'b1, 8'h37, 8'h20, 4'd5},  // R5 acquisition writable
    {1'b0, 8'h37, 8'h20, 4'd5},
    {1'b1, 8'h37, 8'hA0, 4'd5},
    {1'b1, 8'h37, 8'h80, 4'd5},  // R5 ignored in automatic mode
    {1'b0, 8'h37, 8'hA0, 4'd5},
    {1'b1, 8'h37, 8'h00, 4'd5},
    {1'b0, 8'h37, 8'h20, 4'd5},
    {1'b1, 8'h37, 8'h80, 4'd5},
    {1'b0, 8'h37, 8'h80, 4'd5}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input int req);
    bus_addr = a; bus_rd = 1'b1;
    #1 check(bus_rdata, exp, req, "read");
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; lock_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check({7'b0, irq_o}, 8'h00, 1, "R1 irq after reset");
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) do_write(VEC[i][19:12], VEC[i][11:4]);
      else            do_read(VEC[i][19:12], VEC[i][11:4], int'(VEC[i][3:0]));
    end

    // automatic mode on, control 0x30; enable the interrupt (R10)
    do_write(8'h36, 8'hB0);
    do_read(8'h36, 8'hB0, 10);
    check({7'b0, irq_o}, 8'h00, 10, "R10 no irq without flag");

    // rising lock edge timing (R9)
    lock_in = 1'b1;
    @(negedge clk);
    check({7'b0, irq_o}, 8'h00, 9, "R9 irq one edge in");
    bus_addr = 8'h37; bus_rd = 1'b1;
    #1 check(bus_rdata, 8'h80, 9, "R9 lock bit one edge in");
    @(negedge clk);
    #1 check(bus_rdata, 8'hC0, 9, "R9 lock bit two edges in");
    check({7'b0, irq_o}, 8'h00, 9, "R9 irq two edges in");
    bus_rd = 1'b0;
    @(negedge clk);
    check({7'b0, irq_o}, 8'h01, 10, "R10 irq three edges in");
    do_read(8'h36, 8'hF0, 11);
    check({7'b0, irq_o}, 8'h00, 11, "R11 read clears flag");

    // falling edge with a control read on the setting edge (R11 priority)
    lock_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h36; bus_rd = 1'b1;
    #1 check(bus_rdata, 8'hB0, 11, "R11 flag clear before edge");
    @(negedge clk);
    bus_rd = 1'b0;
    check({7'b0, irq_o}, 8'h01, 11, "R11 toggle beats read clear");
    @(negedge clk);
    check({7'b0, irq_o}, 8'h01, 9, "R9 falling edge sets flag");

    // automatic mode off (R4)
    do_write(8'h37, 8'h00);
    check({7'b0, irq_o}, 8'h00, 4, "R4 irq masked");
    do_read(8'h36, 8'h30, 4);
    do_write(8'h36, 8'hB0);
    do_read(8'h36, 8'h30, 4);
    lock_in = 1'b1;
    repeat (3) @(negedge clk);
    do_read(8'h37, 8'h00, 4);
    check({7'b0, irq_o}, 8'h00, 4, "R4 irq after toggle");

    // asynchronous reset mid-run (R1)
    rst_n = 1'b0;
    bus_addr = 8'h36;
    #1 check(bus_rdata, 8'h20, 1, "R1 control in reset");
    bus_addr = 8'h3A;
    #1 check(bus_rdata, 8'h40, 1, "R1 range in reset");
    check({7'b0, irq_o}, 8'h00, 1, "R1 irq in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(8'h3B, 8'h01, 1);

    done = 1'b1;
    finish_run();
  end

endmodule